// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block chooses which analog input the multiplexer of a multi-channel serial converter presents next. A start command begins a scan. The scan order comes from one of nine programmable modes: a channel named by the host in each frame, one channel converted a set number of times, the set bits of a channel mask, a run from channel 0 up to a last channel, a run from a first channel up to the top of the device, or a loaded table of arbitrary channel numbers.

Each mode is bound to one clocking style. Internal-clock modes step on a converter-done handshake and push every result into the result FIFO. External-clock modes step on the 13th falling SCLK edge of each frame. The block takes these edges as single-cycle strobes from the serial front end. It also takes a frame-start strobe, which marks the beginning of each frame.

A start command with a mode and clock source that do not fit together raises an error flag, and the channel is held. The configuration inputs must stay stable while a scan is running.

Top module: `adc_scan_seq`

## Requirements
- R1: Mode codes are: 0 manual, 1 repeat, 2 custom-internal, 3 custom-external, 4 standard-internal, 5 standard-external, 6 upper-internal, 7 upper-external, 8 table. Codes 1, 2, 4 and 6 need `cfg_ext_clk`=0. Codes 0, 3, 5, 7 and 8 need `cfg_ext_clk`=1. A start with an unknown code or the wrong clock source sets `cfg_err`, issues no `conv_start` and leaves `mux_chan` unchanged. A later valid start clears `cfg_err`.
- R2: In manual mode, a start loads `cfg_chan`. On every later 13th falling SCLK edge, `mux_chan` loads the current `cfg_chan` and `conv_start` pulses. `fifo_push` never asserts in this mode.
- R3: Repeat mode converts channel `cfg_chan` exactly `cfg_reps` times, with one `fifo_push` per conversion.
- R4: Custom modes visit, in ascending order, each channel whose bit is set in `cfg_mask` and that is not above the top channel.
- R5: Standard modes visit channels 0 through the lesser of `cfg_chan` and the top channel, in ascending order.
- R6: Upper modes visit channels `cfg_chan` through the top channel. The top channel is 3, 7, 11 or 15 for `cfg_size` 0, 1, 2 or 3.
- R7: Table mode visits table entries 0 to `cfg_tbl_len`-1 in order. Entries are loaded through the write port and may repeat a channel.
- R8: External modes count SCLK falling strobes from the last `frame_start`. The 13th strobe advances to the next channel with a `conv_start` pulse. If the current channel is the last one, that strobe ends the scan instead.
- R9: Internal modes pulse `conv_start` one cycle after a start and one cycle after each `conv_done` that is not the last. Every `conv_done` in a running internal scan gives one `fifo_push` on the next cycle.
- R10: An empty scan completes at the start command with `seq_done` high and no `conv_start`. A scan is empty when no channel is eligible, when `cfg_reps`=0 in repeat mode, or when `cfg_tbl_len`=0 in table mode.
- R11: `seq_done` is a level. It sets when a scan ends and clears on the next accepted non-empty start. Every start begins again at the first entry of the sequence.
- R12: After a synchronous active-low reset, `mux_chan` is 0 and `conv_start`, `fifo_push`, `seq_done` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 4 | Scan mode code |
| cfg_ext_clk | input | 1 | 1 = external (SCLK) clocking selected |
| cfg_chan | input | 4 | Manual/repeat channel, standard last channel, upper first channel |
| cfg_size | input | 2 | Device channel count selector (top channel 3/7/11/15) |
| cfg_mask | input | 16 | Custom channel mask, bit i = channel i |
| cfg_reps | input | 8 | Repeat count |
| cfg_tbl_len | input | 9 | Number of table entries used |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 8 | Table write index |
| tbl_wr_data | input | 4 | Table entry channel |
| start | input | 1 | Start command strobe |
| frame_start | input | 1 | Frame begin strobe |
| sclk_fall | input | 1 | SCLK falling-edge strobe |
| conv_done | input | 1 | Converter done handshake |
| mux_chan | output | 4 | Selected multiplexer channel |
| conv_start | output | 1 | Conversion start pulse |
| fifo_push | output | 1 | Result FIFO push pulse |
| seq_done | output | 1 | Sequence complete flag |
| cfg_err | output | 1 | Mode/clock mismatch flag |

## Verification
The bench targets the 13th-edge boundary in manual mode. After 12 strobes the channel must not have moved yet, so a design off by one edge would switch early or late. It also runs a mask with all bits above the top channel, a zero repeat count and a single-channel upper scan. A design that mishandles these would start a conversion or hang instead of finishing at once. Mismatched mode and clock pairs must leave the channel frozen, and a repeated scan must restart from its first channel. Push counts separate internal from external modes, which catches a design that fills the FIFO while SCLK is doing the clocking.

// File: rtl/adc_scan_pkg.sv
// Shared mode codes and mode helpers for the scan sequencer.
package adc_scan_pkg;

    typedef enum logic [3:0] {
        SCAN_MANUAL   = 4'd0,
        SCAN_REPEAT   = 4'd1,
        SCAN_CUST_INT = 4'd2,
        SCAN_CUST_EXT = 4'd3,
        SCAN_STD_INT  = 4'd4,
        SCAN_STD_EXT  = 4'd5,
        SCAN_UP_INT   = 4'd6,
        SCAN_UP_EXT   = 4'd7,
        SCAN_TABLE    = 4'd8
    } scan_mode_e;

    // True for any defined mode code.
    function automatic logic mode_known(input logic [3:0] m);
        return m <= 4'd8;
    endfunction

    // True when the mode is clocked by SCLK rather than the converter handshake.
    function automatic logic mode_needs_ext(input logic [3:0] m);
        return (m == SCAN_MANUAL) || (m == SCAN_CUST_EXT) || (m == SCAN_STD_EXT) ||
               (m == SCAN_UP_EXT) || (m == SCAN_TABLE);
    endfunction

endpackage

// File: rtl/scan_elig.sv
// Builds the per-channel eligibility vector for the mask, standard and upper
// modes, clipped to the top channel given by the channel count selector.
// Assumes NCH is a multiple of four.
module scan_elig
    import adc_scan_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [3:0]      mode,
    input  logic [CH_W-1:0] chan,
    input  logic [1:0]      size,
    input  logic [NCH-1:0]  mask,
    output logic [NCH-1:0]  elig,
    output logic [CH_W-1:0] top
);
    localparam int QUART = NCH / 4;

    logic is_cust, is_std, is_up;

    // Decode the mode family and the highest channel of the device.
    always_comb begin
        is_cust = (mode == SCAN_CUST_INT) || (mode == SCAN_CUST_EXT);
        is_std  = (mode == SCAN_STD_INT)  || (mode == SCAN_STD_EXT);
        is_up   = (mode == SCAN_UP_INT)   || (mode == SCAN_UP_EXT);
        top     = CH_W'((int'(size) + 1) * QUART - 1);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_bit
        assign elig[i] = (CH_W'(i) <= top) &&
                         ((is_cust && mask[i]) ||
                          (is_std  && (CH_W'(i) <= chan)) ||
                          (is_up   && (CH_W'(i) >= chan)));
    end

endmodule

// File: rtl/scan_pick.sv
// Priority finder: lowest eligible channel, and lowest eligible channel
// strictly above the current one. Purely combinational.
module scan_pick #(
    parameter int NCH  = 16,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  elig,
    input  logic [CH_W-1:0] cur,
    output logic [CH_W-1:0] first,
    output logic            first_ok,
    output logic [CH_W-1:0] next,
    output logic            next_ok
);
    // Scan from the top down so the lowest qualifying index is kept last.
    always_comb begin
        first    = '0;
        first_ok = 1'b0;
        next     = '0;
        next_ok  = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                first    = CH_W'(i);
                first_ok = 1'b1;
                if (CH_W'(i) > cur) begin
                    next    = CH_W'(i);
                    next_ok = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/scan_table.sv
// Channel table for table mode: one write port, one asynchronous read port.
// Contents are not reset; the host loads entries before use.
module scan_table #(
    parameter int DEPTH = 256,
    parameter int CH_W  = 4,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [CH_W-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CH_W-1:0]  rd_data
);
    logic [CH_W-1:0] mem [DEPTH];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer top. Accepts a start command, validates the mode against
// the clock source, then steps the multiplexer channel either on converter
// done (internal modes) or on the ADV_EDGE-th SCLK falling strobe of a frame
// (external modes). Assumes configuration inputs are stable while running.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH      = 16,
    parameter int TBL_DEPTH = 256,
    parameter int CNT_W    = 8,
    parameter int ADV_EDGE = 13,
    localparam int CH_W    = $clog2(NCH),
    localparam int IDX_W   = $clog2(TBL_DEPTH),
    localparam int LEN_W   = IDX_W + 1,
    localparam int EC_W    = $clog2(ADV_EDGE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_mode,
    input  logic             cfg_ext_clk,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic [1:0]       cfg_size,
    input  logic [NCH-1:0]   cfg_mask,
    input  logic [CNT_W-1:0] cfg_reps,
    input  logic [LEN_W-1:0] cfg_tbl_len,
    input  logic             tbl_wr_en,
    input  logic [IDX_W-1:0] tbl_wr_addr,
    input  logic [CH_W-1:0]  tbl_wr_data,
    input  logic             start,
    input  logic             frame_start,
    input  logic             sclk_fall,
    input  logic             conv_done,
    output logic [CH_W-1:0]  mux_chan,
    output logic             conv_start,
    output logic             fifo_push,
    output logic             seq_done,
    output logic             cfg_err
);
    logic [NCH-1:0]   elig;
    logic [CH_W-1:0]  top_chan, pick_first, pick_next, tbl_data;
    logic             pick_first_ok, pick_next_ok;
    logic             run;
    logic [IDX_W-1:0] ptr, tbl_rd_addr;
    logic [CNT_W-1:0] rep_cnt;
    logic [EC_W-1:0]  edge_cnt;
    logic             is_ext, is_manual, is_rep, is_tbl, bad_cfg;
    logic             empty, last, adv;
    logic [CH_W-1:0]  first_chan, next_chan;

    scan_elig #(.NCH(NCH), .CH_W(CH_W)) u_elig (
        .mode(cfg_mode), .chan(cfg_chan), .size(cfg_size), .mask(cfg_mask),
        .elig(elig), .top(top_chan)
    );

    scan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .elig(elig), .cur(mux_chan),
        .first(pick_first), .first_ok(pick_first_ok),
        .next(pick_next), .next_ok(pick_next_ok)
    );

    scan_table #(.DEPTH(TBL_DEPTH), .CH_W(CH_W), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr), .wr_data(tbl_wr_data),
        .rd_addr(tbl_rd_addr), .rd_data(tbl_data)
    );

    // Mode checks and per-mode first/next/last selection.
    always_comb begin
        is_ext      = mode_needs_ext(cfg_mode);
        is_manual   = (cfg_mode == SCAN_MANUAL);
        is_rep      = (cfg_mode == SCAN_REPEAT);
        is_tbl      = (cfg_mode == SCAN_TABLE);
        bad_cfg     = !mode_known(cfg_mode) || (is_ext != cfg_ext_clk);
        tbl_rd_addr = start ? '0 : IDX_W'(ptr + 1'b1);
        if (is_manual) begin
            first_chan = cfg_chan;  next_chan = cfg_chan;
            empty = 1'b0;           last = 1'b0;
        end else if (is_rep) begin
            first_chan = cfg_chan;  next_chan = mux_chan;
            empty = (cfg_reps == '0);
            last  = (rep_cnt == cfg_reps - 1'b1);
        end else if (is_tbl) begin
            first_chan = tbl_data;  next_chan = tbl_data;
            empty = (cfg_tbl_len == '0);
            last  = ({1'b0, ptr} == cfg_tbl_len - 1'b1);
        end else begin
            first_chan = pick_first; next_chan = pick_next;
            empty = !pick_first_ok;  last = !pick_next_ok;
        end
        adv = run && (is_ext ? (sclk_fall && !frame_start &&
                                edge_cnt == EC_W'(ADV_EDGE - 1))
                             : conv_done);
    end

    // Count SCLK falling strobes since the last frame start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                                edge_cnt <= '0;
        else if (frame_start)                      edge_cnt <= '0;
        else if (sclk_fall && edge_cnt != EC_W'(ADV_EDGE)) edge_cnt <= edge_cnt + 1'b1;
    end

    // Scan control: start acceptance, stepping, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; mux_chan <= '0; conv_start <= 1'b0; fifo_push <= 1'b0;
            seq_done <= 1'b0; cfg_err <= 1'b0; ptr <= '0; rep_cnt <= '0;
        end else begin
            conv_start <= 1'b0;
            fifo_push  <= 1'b0;
            if (start) begin
                cfg_err <= bad_cfg;
                ptr     <= '0;
                rep_cnt <= '0;
                if (bad_cfg) begin
                    run <= 1'b0;
                end else if (empty) begin
                    run <= 1'b0; seq_done <= 1'b1;
                end else begin
                    run <= 1'b1; seq_done <= 1'b0;
                    mux_chan <= first_chan; conv_start <= 1'b1;
                end
            end else if (adv) begin
                fifo_push <= !is_ext;
                if (last) begin
                    run <= 1'b0; seq_done <= 1'b1;
                end else begin
                    mux_chan <= next_chan; conv_start <= 1'b1;
                    ptr <= ptr + 1'b1; rep_cnt <= rep_cnt + 1'b1;
                end
            end
        end
    end

    // R9: a push only ever follows a converter-done handshake.
    a_r9_push_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> $past(conv_done));
    // R10: a finished or empty scan never launches a conversion.
    a_r10_done_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !conv_start);
    // R1: a rejected configuration starts nothing.
    a_r1_err_no_conv: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !conv_start);
    // R1: while idle and not commanded, the channel is frozen.
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(mux_chan));
    // R4: the picker only ever moves upward.
    a_r4_next_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        pick_next_ok |-> (pick_next > mux_chan));
    // R8: the frame edge counter never passes its ceiling.
    a_r8_edge_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= EC_W'(ADV_EDGE));

endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;

    typedef struct packed {
        logic [3:0]  mode;
        logic        ext;
        logic [3:0]  chan;
        logic [1:0]  size;
        logic [15:0] mask;
        logic [7:0]  reps;
        logic [8:0]  tlen;
        logic [7:0]  nexp;
        logic [63:0] seq;   // entry k in bits 4k+3:4k
        logic [7:0]  pexp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b0, 4'd0,  2'd3, 16'h8421, 8'd0, 9'd0, 8'd4,  64'hFA50,         8'd4,  8'd4},  // R4 R9 custom int
        '{4'd5, 1'b1, 4'd3,  2'd3, 16'h0000, 8'd0, 9'd0, 8'd4,  64'h3210,         8'd0,  8'd5},  // R5 R8 standard ext
        '{4'd6, 1'b0, 4'd5,  2'd1, 16'h0000, 8'd0, 9'd0, 8'd3,  64'h765,          8'd3,  8'd6},  // R6 upper int, top 7
        '{4'd1, 1'b0, 4'd9,  2'd3, 16'h0000, 8'd3, 9'd0, 8'd3,  64'h999,          8'd3,  8'd3},  // R3 repeat
        '{4'd8, 1'b1, 4'd0,  2'd3, 16'h0000, 8'd0, 9'd5, 8'd5,  64'h20272,        8'd0,  8'd7},  // R7 table
        '{4'd3, 1'b1, 4'd0,  2'd0, 16'hF0F0, 8'd0, 9'd0, 8'd0,  64'h0,            8'd0,  8'd10}, // R10 mask above top
        '{4'd4, 1'b0, 4'd12, 2'd2, 16'h0000, 8'd0, 9'd0, 8'd12, 64'hBA9876543210, 8'd12, 8'd5},  // R5 clipped to 11
        '{4'd7, 1'b1, 4'd15, 2'd3, 16'h0000, 8'd0, 9'd0, 8'd1,  64'hF,            8'd0,  8'd6},  // R6 single channel
        '{4'd1, 1'b0, 4'd2,  2'd3, 16'h0000, 8'd0, 9'd0, 8'd0,  64'h0,            8'd0,  8'd10}, // R10 zero repeats
        '{4'd2, 1'b0, 4'd0,  2'd3, 16'h8421, 8'd0, 9'd0, 8'd4,  64'hFA50,         8'd4,  8'd11}  // R11 restart
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cfg_mode;
    logic        cfg_ext_clk;
    logic [3:0]  cfg_chan;
    logic [1:0]  cfg_size;
    logic [15:0] cfg_mask;
    logic [7:0]  cfg_reps;
    logic [8:0]  cfg_tbl_len;
    logic        tbl_wr_en;
    logic [7:0]  tbl_wr_addr;
    logic [3:0]  tbl_wr_data;
    logic        start, frame_start, sclk_fall, conv_done;
    logic [3:0]  mux_chan;
    logic        conv_start, fifo_push, seq_done, cfg_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    adc_scan_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_ext_clk(cfg_ext_clk),
        .cfg_chan(cfg_chan), .cfg_size(cfg_size), .cfg_mask(cfg_mask),
        .cfg_reps(cfg_reps), .cfg_tbl_len(cfg_tbl_len), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data), .start(start),
        .frame_start(frame_start), .sclk_fall(sclk_fall), .conv_done(conv_done),
        .mux_chan(mux_chan), .conv_start(conv_start), .fifo_push(fifo_push),
        .seq_done(seq_done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tbl_write(input int a, input logic [3:0] d);
        tbl_wr_en = 1'b1; tbl_wr_addr = 8'(a); tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [3:0] m, input logic e, input logic [3:0] c);
        cfg_mode = m; cfg_ext_clk = e; cfg_chan = c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: all requirements, actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 0; frame_start = 0; sclk_fall = 0; conv_done = 0;
        tbl_wr_en = 0; tbl_wr_addr = 0; tbl_wr_data = 0;
        set_cfg(4'd0, 1'b1, 4'd0); cfg_size = 2'd3; cfg_mask = '0; cfg_reps = '0; cfg_tbl_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(mux_chan == 0 && !conv_start && !fifo_push && !seq_done && !cfg_err, "R12",
            {mux_chan, conv_start, fifo_push, seq_done, cfg_err}, 64'h0);

        // Load the table used by the R7 vector: 2,7,2,0,2
        tbl_write(0, 4'd2); tbl_write(1, 4'd7); tbl_write(2, 4'd2);
        tbl_write(3, 4'd0); tbl_write(4, 4'd2);

        for (int v = 0; v < NV; v++) begin
            automatic vec_t  t = VECS[v];
            automatic int    n = 0, pushes = 0, dly = 0;
            automatic logic [63:0] seen = '0;
            automatic bit    done = 0;
            automatic string tag = $sformatf("R%0d", t.rq);
            set_cfg(t.mode, t.ext, t.chan);
            cfg_size = t.size; cfg_mask = t.mask; cfg_reps = t.reps; cfg_tbl_len = t.tlen;
            start = 1'b1;
            for (int k = 0; k < 600 && !done; k++) begin
                @(negedge clk);
                start = 1'b0;
                if (conv_start) begin
                    if (n < 16) seen[4*n +: 4] = mux_chan;
                    n++;
                    dly = 2;
                end
                if (fifo_push) pushes++;
                if (seq_done) done = 1;
                conv_done = 1'b0;
                if (!t.ext && dly > 0) begin
                    dly--;
                    if (dly == 0) conv_done = 1'b1;
                end
                frame_start = t.ext && (k % 20 == 0);
                sclk_fall   = t.ext && (k % 20 >= 1) && (k % 20 <= 16);
            end
            conv_done = 0; frame_start = 0; sclk_fall = 0;
            chk(done, tag, done, 1);
            chk(n == int'(t.nexp), tag, n, t.nexp);
            chk(seen == t.seq, tag, seen, t.seq);
            chk(pushes == int'(t.pexp), tag, pushes, t.pexp);   // R9 internal pushes, none external
            chk(!cfg_err, tag, cfg_err, 0);
            @(negedge clk);
        end

        // R2 / R8: manual mode switches on the 13th falling strobe, never pushes
        begin
            automatic int pushes = 0;
            set_cfg(4'd0, 1'b1, 4'd6);
            start = 1'b1; @(negedge clk); start = 1'b0;
            chk(mux_chan == 6 && conv_start, "R2", {mux_chan, conv_start}, {4'd6, 1'b1});
            cfg_chan = 4'd11;
            frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
            repeat (12) begin
                sclk_fall = 1'b1; @(negedge clk);
                if (fifo_push) pushes++;
            end
            sclk_fall = 1'b0;
            chk(mux_chan == 6, "R8", mux_chan, 6);
            sclk_fall = 1'b1; @(negedge clk); sclk_fall = 1'b0;
            chk(mux_chan == 11 && conv_start, "R8", {mux_chan, conv_start}, {4'd11, 1'b1});
            repeat (3) begin
                conv_done = 1'b1; @(negedge clk);
                if (fifo_push) pushes++;
            end
            conv_done = 1'b0; @(negedge clk);
            if (fifo_push) pushes++;
            chk(pushes == 0 && mux_chan == 11, "R2", {pushes[3:0], mux_chan}, {4'd0, 4'd11});
        end

        // R1: mismatched clock, table on internal clock, unknown code
        begin
            automatic logic [3:0] bad_modes [3] = '{4'd2, 4'd8, 4'd12};
            automatic logic       bad_ext   [3] = '{1'b1, 1'b0, 1'b1};
            for (int b = 0; b < 3; b++) begin
                automatic int cs = 0;
                set_cfg(bad_modes[b], bad_ext[b], 4'd3);
                cfg_mask = 16'h0010; cfg_tbl_len = 9'd5;
                start = 1'b1; @(negedge clk); start = 1'b0;
                if (conv_start) cs++;
                repeat (4) begin
                    conv_done = 1'b1; sclk_fall = 1'b1; @(negedge clk);
                    if (conv_start) cs++;
                end
                conv_done = 0; sclk_fall = 0;
                chk(cfg_err && cs == 0 && mux_chan == 11, "R1",
                    {cfg_err, cs[3:0], mux_chan}, {1'b1, 4'd0, 4'd11});
            end
            set_cfg(4'd2, 1'b0, 4'd0); cfg_mask = 16'h0010;
            start = 1'b1; @(negedge clk); start = 1'b0;
            chk(!cfg_err && mux_chan == 4 && conv_start, "R1",
                {cfg_err, mux_chan, conv_start}, {1'b0, 4'd4, 1'b1});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule